// File: doc/BRIEF.md
# Four-Way Time-Interleaved ALU Array

This block keeps the throughput of a single ALU while giving each copy of the datapath four fast clocks to settle. It holds four identical combinational ALU copies. Each copy has its own operand register, and that register loads on only one of four rotating one-hot phases. A 2-bit select trails the phases and picks the copy whose result has settled. A single output register clocked every cycle captures that result. The block accepts one operand set on every fast clock and returns one result on every fast clock. Results leave in the order their operands arrived.

The parameter `LAT` sets how many fast cycles a copy has to settle before its result is sampled. The allowed range is 1 to 4. A valid bit travels with each operand set, so the output is flagged valid only for slots that carried a valid input after reset. Each ALU copy takes a 4-bit operation code, a carry/borrow input and two `W`-bit operands.

Top module: `interleaved_alu`

## Requirements
- R1: `phase_oh` is one-hot in every cycle out of reset. The set bit moves from bit 0 to bit 1, then bit 2, then bit 3 and back to bit 0, one step per clock. After a synchronous reset bit 0 is set.
- R2: `mux_sel` advances by one (modulo 4) each clock. It always equals the active phase index minus `LAT`, modulo 4. It is therefore 00 after reset when `LAT` is 4, and 11 when `LAT` is 1.
- R3: Copy k captures the inputs only at a clock edge where phase bit k is active. It then holds them unchanged for the next three clocks.
- R4: An operand set captured at clock edge n appears on `out_res`/`out_carry` right after edge n+`LAT`. Operand sets captured on consecutive edges leave on consecutive edges, in the same order.
- R5: `out_valid` equals the `in_valid` that accompanied the operand set now shown. A slot entered with `in_valid` low yields `out_valid` low.
- R6: After reset, `out_valid` stays low for the first `LAT` clocks, until the first captured operand set reaches the output.
- R7: Opcode 0000 gives {carry,result} = a + b + cin. Opcode 0001 gives result = a − b − cin, with `out_carry` set when a borrow occurs (a < b + cin).
- R8: Opcode 0010 gives result 1 when a equals b and 0 otherwise. Opcode 0011 gives the opposite. Bit 0 carries the answer and all upper bits are 0.
- R9: The logic and pass opcodes are: 0100 XOR, 0101 NOR, 0110 OR, 0111 AND, 1000 pass a, 1001 pass b, 1010 NAND. Opcodes 1011 to 1111 give an all-zero result. Every opcode other than 0000 and 0001 gives `out_carry` = 0.
- R10: A synchronous reset in mid-run drops results already in flight. After reset, `out_valid` is low, `phase_oh` is 0001, and the R6 fill period starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set on this clock is meaningful |
| in_a | input | W | Operand a |
| in_b | input | W | Operand b |
| in_op | input | 4 | Operation code |
| in_cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| out_valid | output | 1 | Registered result is valid |
| out_res | output | W | Registered result |
| out_carry | output | 1 | Registered carry/borrow out |
| phase_oh | output | 4 | One-hot load phase currently active |
| mux_sel | output | 2 | Copy selected for the output register |

## Verification
The bench builds two instances at `W` = 16 and drives the same inputs into both. One uses `LAT` = 4, the longest settle window, where a copy is sampled on the same edge it reloads. The other uses `LAT` = 1, where the select trails the phase by a single cycle and sits at 11 out of reset. Together they cover both ends of the select offset and the one-result-per-clock ordering. Gaps in `in_valid`, a mid-run reset and carry/borrow edge operands are also exercised at both latencies.

// File: rtl/interleaved_alu.sv
module interleaved_alu #(
  parameter int W   = 16,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [3:0]   in_op,
  input  logic         in_cin,
  output logic         out_valid,
  output logic [W-1:0] out_res,
  output logic         out_carry,
  output logic [3:0]   phase_oh,
  output logic [1:0]   mux_sel
);

  localparam int LANES = 4;
  localparam int OPW   = 2 * W + 6;
  localparam logic [1:0] LAG = 2'(LAT % 4);

  initial lat_range_chk: assert (LAT >= 1 && LAT <= 4);

  function automatic logic [W:0] alu_eval(input logic [3:0] op, input logic cin,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] r;
    case (op)
      4'h0:    r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      4'h1:    r = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      4'h2:    r = {{W{1'b0}}, a == b};
      4'h3:    r = {{W{1'b0}}, a != b};
      4'h4:    r = {1'b0, a ^ b};
      4'h5:    r = {1'b0, ~(a | b)};
      4'h6:    r = {1'b0, a | b};
      4'h7:    r = {1'b0, a & b};
      4'h8:    r = {1'b0, a};
      4'h9:    r = {1'b0, b};
      4'hA:    r = {1'b0, ~(a & b)};
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [1:0]     ph;
  logic [OPW-1:0] cp_q     [LANES];
  logic [W:0]     lane_out [LANES];
  logic [LANES-1:0] lane_vld;

  always_ff @(posedge clk) begin
    if (rst) ph <= 2'd0;
    else     ph <= ph + 2'd1;
  end

  assign phase_oh = 4'b0001 << ph;
  assign mux_sel  = ph - LAG;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            cp_q[k] <= '0;
      else if (phase_oh[k]) cp_q[k] <= {in_valid, in_op, in_cin, in_a, in_b};
    end

    assign lane_vld[k] = cp_q[k][OPW-1];
    assign lane_out[k] = alu_eval(cp_q[k][2*W+4:2*W+1], cp_q[k][2*W],
                                  cp_q[k][2*W-1:W], cp_q[k][W-1:0]);

    // R3
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(phase_oh[k])) |-> $stable(cp_q[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= lane_vld[mux_sel];
      {out_carry, out_res} <= lane_out[mux_sel];
    end
  end

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  // R1
  phase_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_oh == {$past(phase_oh[2:0]), $past(phase_oh[3])});

  // R2
  mux_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mux_sel == $past(mux_sel) + 2'd1);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase_oh == 4'b0001 && !out_valid));

endmodule

// File: tb/test_interleaved_alu.sv
module test_interleaved_alu;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, in_valid, in_cin;
  logic [W-1:0] in_a, in_b;
  logic [3:0]   in_op;
  logic         v4, c4, v1, c1;
  logic [W-1:0] r4, r1;
  logic [3:0]   p4, p1;
  logic [1:0]   s4, s1;

  interleaved_alu #(.W(W), .LAT(4)) i_interleaved_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .in_cin(in_cin), .out_valid(v4), .out_res(r4),
    .out_carry(c4), .phase_oh(p4), .mux_sel(s4));

  interleaved_alu #(.W(W), .LAT(1)) i_interleaved_alu_l1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_op(in_op), .in_cin(in_cin), .out_valid(v1), .out_res(r1),
    .out_carry(c1), .phase_oh(p1), .mux_sel(s1));

  // {valid, op, cin, a, b}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 4'h0, 1'b0, 16'hFFFF, 16'h0001},
    {1'b1, 4'h0, 1'b1, 16'h1234, 16'h0FFF},
    {1'b1, 4'h1, 1'b0, 16'hAAAA, 16'h1555},
    {1'b1, 4'h1, 1'b1, 16'h0005, 16'h0005},
    {1'b1, 4'h2, 1'b0, 16'h5A5A, 16'h5A5A},
    {1'b1, 4'h3, 1'b0, 16'h5555, 16'hAAAA},
    {1'b1, 4'h4, 1'b0, 16'h5555, 16'hAAAA},
    {1'b1, 4'h5, 1'b1, 16'h0F0F, 16'h00FF},
    {1'b0, 4'h6, 1'b0, 16'h0F0F, 16'hF000},
    {1'b1, 4'h7, 1'b0, 16'h166D, 16'h54AA},
    {1'b1, 4'h8, 1'b1, 16'hBEEF, 16'h1111},
    {1'b1, 4'h9, 1'b0, 16'hBEEF, 16'h2222},
    {1'b1, 4'hA, 1'b0, 16'h6666, 16'h0000},
    {1'b1, 4'hC, 1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 4'h2, 1'b0, 16'h0001, 16'h0002},
    {1'b1, 4'h1, 1'b0, 16'h166D, 16'h54AA}
  };

  int checks = 0, fails = 0, e = 0;
  logic       hv [0:1023];
  logic [W:0] hr [0:1023];

  function automatic logic [W:0] model(input logic [3:0] op, input logic cin,
                                       input logic [W-1:0] a, input logic [W-1:0] b);
    int unsigned s;
    logic [W:0] r;
    r = '0;
    case (op)
      4'h0: begin s = a + b + cin; r = s[W:0]; end
      4'h1: begin r[W-1:0] = a - b - W'(cin); r[W] = (int'(a) < int'(b) + int'(cin)); end
      4'h2: r[0] = (a == b);
      4'h3: r[0] = (a != b);
      4'h4: r[W-1:0] = a ^ b;
      4'h5: r[W-1:0] = ~(a | b);
      4'h6: r[W-1:0] = a | b;
      4'h7: r[W-1:0] = a & b;
      4'h8: r[W-1:0] = a;
      4'h9: r[W-1:0] = b;
      4'hA: r[W-1:0] = ~(a & b);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", rq, act, exp, e);
    end
  endtask

  task automatic check_out(input int lat, input logic v, input logic [W-1:0] r, input logic c,
                           input logic [3:0] p, input logic [1:0] s);
    int idx;
    logic ev;
    idx = e - lat;
    ev = (idx >= 1) ? hv[idx] : 1'b0;
    chk(idx >= 1 ? "R5 valid" : "R6 fill", 32'(v), 32'(ev));
    chk("R1 phase", 32'(p), 32'(4'b0001 << (e % 4)));
    chk("R2 select", 32'(s), 32'((e - lat) & 3));
    if (ev) chk("R4/R7/R8/R9 result", 32'({c, r}), 32'(hr[idx]));
  endtask

  task automatic step(input logic [37:0] vec);
    {in_valid, in_op, in_cin, in_a, in_b} = vec;
    @(posedge clk);
    e++;
    hv[e] = vec[37];
    hr[e] = model(vec[36:33], vec[32], vec[31:16], vec[15:0]);
    @(negedge clk);
    check_out(4, v4, r4, c4, p4, s4);
    check_out(1, v1, r1, c1, p1, s1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e = 0;
    for (int i = 0; i < 1024; i++) hv[i] = 1'b0;
    // R10 / R1 / R2 reset state
    chk("R10 valid4", 32'(v4), 0);
    chk("R10 valid1", 32'(v1), 0);
    chk("R1 reset phase", 32'(p4), 32'h1);
    chk("R2 reset sel L4", 32'(s4), 32'h0);
    chk("R2 reset sel L1", 32'(s1), 32'h3);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_op = '0; in_cin = 1'b0;
    @(negedge clk);
    do_reset();
    // R4 R7 R8 R9: table walk, one operand set per clock
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R5: idle slots then a burst
    for (int i = 0; i < 3; i++) step({1'b0, 4'h0, 1'b0, 16'h1111, 16'h2222});
    for (int i = 0; i < 8; i++) step({1'b1, 4'h0, 1'b0, 16'(i * 4097), 16'(65535 - i)});
    // R7 borrow boundary: a = b + cin
    step({1'b1, 4'h1, 1'b1, 16'h0000, 16'hFFFF});
    step({1'b1, 4'h1, 1'b1, 16'h0001, 16'h0000});
    step({1'b1, 4'h0, 1'b1, 16'hFFFF, 16'hFFFF});
    for (int i = 0; i < 5; i++) step({1'b0, 4'h0, 1'b0, 16'h0, 16'h0});
    // R10: reset mid-run drops in-flight results, R6 fill restarts
    for (int i = 0; i < 2; i++) step({1'b1, 4'h4, 1'b0, 16'hF0F0, 16'h0FF0});
    in_valid = 1'b1;
    do_reset();
    for (int i = 0; i < 6; i++) step({1'b1, 4'h7, 1'b0, 16'(i + 3), 16'hFFFE});
    for (int i = 0; i < 5; i++) step({1'b0, 4'h0, 1'b0, 16'h0, 16'h0});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule